// File: doc/BRIEF.md
# Preset-Loadable Count Channel

One channel of a multi-channel position-counter interface. It is reached over an 8-bit bus with two addresses: a data port that moves the 24-bit preset in and the 24-bit output latch out one byte at a time, and a control port. Writes to the control port are command bytes, and reads from it return a status byte. The count pulse and the count direction come from an external quadrature or pulse decoder. The block only gates those pulses and applies the selected count mode.

The preset has two roles. It is the value loaded into the counter, either by command or by an index edge. It is also the upper limit in the range-limit and modulo-N modes. Software normally works in this order: point the byte pointer at the low byte, write three preset bytes, issue a transfer command, and read the count back through the output latch after a latch command.

Top module: `preset_counter_ch`

## Requirements
- R1: After reset, the counter, preset, output latch, byte pointer, modes and flags are all zero, except the direction flag, which is 1. The count gate is off, so the status byte reads 0x20.
- R2: In a control-port write, bits 6:5 select the target. 00 is a reset/load command. 01 sets the count mode from bits 2:1 (0 normal, 1 range limit, 2 non-recycle, 3 modulo-N). 10 is I/O control: bit 0 enables counting and bit 1 = 1 blocks index loads. 11 is index control: bit 0 enables the index function and bit 1 selects a rising (1) or falling (0) active edge.
- R3: Each data-port access moves one byte, least significant byte first. A write stores into the preset and a read returns the output latch. The pointer advances after every access and wraps to the low byte after the third. A reset/load command with bit 0 set returns the pointer to the low byte.
- R4: Reset/load field 4:3 selects a transfer. 1 copies the preset into the counter and releases a non-recycle freeze. 2 copies the counter into the output latch, which then holds that value while counting goes on. 3 copies the preset's low byte to the prescaler output `psc_o`.
- R5: In normal mode, counting up from 0xFFFFFF gives 0 and sets the carry flag and clears the sign flag. Counting down from 0 gives 0xFFFFFF and sets the borrow and sign flags.
- R6: In range-limit mode, the counter stays at the preset when counting up and stays at 0 when counting down, and sets carry or borrow respectively.
- R7: Non-recycle mode wraps like normal mode. After a carry or borrow the counter freezes and ignores count pulses until the next preset load.
- R8: In modulo-N mode, counting up from the preset gives 0 with carry, and counting down from 0 gives the preset with borrow.
- R9: The compare flag is set by any count step whose result equals the preset.
- R10: The status byte holds borrow (bit 0), carry (bit 1), compare (bit 2), sign (bit 3), error (bit 4), direction (bit 5), index (bit 6) and 0 in bit 7. Reset/load field 2:1 = 2 clears borrow, carry, compare, sign and index. Field 2:1 = 3 clears error. A pulse on `noise_in` sets error.
- R11: The direction flag takes the value of `cnt_up` on every count step that is taken.
- R12: While the I/O-control count enable is 0, count pulses leave the counter unchanged.
- R13: With the index function enabled, an active edge on `index_pin` sets the index flag. It also loads the preset into the counter unless I/O-control bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ctrl | input | 1 | 1 addresses the control/status port, 0 the data port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; the pointer advances on the clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (status or latch byte), combinational |
| cnt_en | input | 1 | One-cycle count pulse from the decoder |
| cnt_up | input | 1 | Direction of the pulse, 1 = up |
| index_pin | input | 1 | Index input level |
| noise_in | input | 1 | Noise-detected pulse that sets the error flag |
| psc_o | output | 8 | Prescaler value taken from the preset's low byte |

## Verification
On every cycle, the assertions check these properties:
- the byte pointer stays within range;
- a gated-off or frozen counter does not move;
- range-limit holds at the preset;
- modulo-N wraps the preset to zero;
- a noise pulse always leaves the error flag set.

The mode-dependent results over several steps can only be shown by the bench's scenarios. These include:
- wrap values and flag combinations in the status byte;
- the pointer reset in the middle of a read;
- the latch holding while the counter moves on;
- index loads being blocked by the I/O-control bit.

// File: rtl/preset_counter_ch.sv
module preset_counter_ch #(
  parameter int W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_ctrl,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cnt_en,
  input  logic       cnt_up,
  input  logic       index_pin,
  input  logic       noise_in,
  output logic [7:0] psc_o
);
  localparam int BYTES = W / 8;
  localparam int PW = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [1:0] M_NORM = 2'd0, M_RLIM = 2'd1, M_NREC = 2'd2, M_MODN = 2'd3;

  logic [W-1:0] cnt, preset, latch, nxt;
  logic [PW-1:0] ptr;
  logic [1:0] cmode;
  logic gate, ld_dis, idx_en, idx_pol, idx_q, frozen;
  logic f_bor, f_car, f_cmp, f_sign, f_err, f_dir, f_idx;
  logic hit_c, hit_b;

  wire ctl_wr = bus_wr & bus_ctrl;
  wire dat_wr = bus_wr & ~bus_ctrl;
  wire dat_rd = bus_rd & ~bus_ctrl;
  wire rld    = ctl_wr & (bus_wdata[6:5] == 2'b00);
  wire rst_bp = rld & bus_wdata[0];
  wire clr_fl = rld & (bus_wdata[2:1] == 2'd2);
  wire clr_er = rld & (bus_wdata[2:1] == 2'd3);
  wire ld_pr  = rld & (bus_wdata[4:3] == 2'd1);
  wire ld_ol  = rld & (bus_wdata[4:3] == 2'd2);
  wire ld_psc = rld & (bus_wdata[4:3] == 2'd3);
  wire idx_evt  = idx_en & (idx_pol ? (index_pin & ~idx_q) : (~index_pin & idx_q));
  wire idx_load = idx_evt & ~ld_dis;
  wire load_any = ld_pr | idx_load;
  wire step     = cnt_en & gate & ~frozen;

  assign bus_rdata = bus_ctrl ? {1'b0, f_idx, f_dir, f_err, f_sign, f_cmp, f_car, f_bor}
                              : latch[8*ptr +: 8];

  always_comb begin
    nxt = cnt;
    hit_c = 1'b0;
    hit_b = 1'b0;
    if (cnt_up) begin
      if (cmode == M_RLIM || cmode == M_MODN) begin
        if (cnt == preset) begin
          hit_c = 1'b1;
          nxt = (cmode == M_MODN) ? '0 : cnt;
        end else nxt = cnt + 1'b1;
      end else begin
        hit_c = (cnt == MAXV);
        nxt = cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        hit_b = 1'b1;
        case (cmode)
          M_RLIM:  nxt = cnt;
          M_MODN:  nxt = preset;
          default: nxt = MAXV;
        endcase
      end else nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; preset <= '0; latch <= '0; ptr <= '0; psc_o <= '0;
      cmode <= M_NORM; gate <= 1'b0; ld_dis <= 1'b0; idx_en <= 1'b0; idx_pol <= 1'b0;
      idx_q <= 1'b0; frozen <= 1'b0;
      f_bor <= 1'b0; f_car <= 1'b0; f_cmp <= 1'b0; f_sign <= 1'b0;
      f_err <= 1'b0; f_dir <= 1'b1; f_idx <= 1'b0;
    end else begin
      idx_q <= index_pin;
      if (ctl_wr && bus_wdata[6:5] == 2'b01) cmode <= bus_wdata[2:1];
      if (ctl_wr && bus_wdata[6:5] == 2'b10) begin gate <= bus_wdata[0]; ld_dis <= bus_wdata[1]; end
      if (ctl_wr && bus_wdata[6:5] == 2'b11) begin idx_en <= bus_wdata[0]; idx_pol <= bus_wdata[1]; end
      if (rst_bp) ptr <= '0;
      else if (dat_wr || dat_rd) ptr <= (ptr == PW'(BYTES-1)) ? '0 : ptr + 1'b1;
      if (dat_wr) preset[8*ptr +: 8] <= bus_wdata;
      if (ld_ol) latch <= cnt;
      if (ld_psc) psc_o <= preset[7:0];
      if (load_any) begin
        cnt <= preset;
        frozen <= 1'b0;
      end else if (step) begin
        cnt <= nxt;
        if (cmode == M_NREC && (hit_c || hit_b)) frozen <= 1'b1;
      end
      if (clr_fl) begin f_bor <= 1'b0; f_car <= 1'b0; f_cmp <= 1'b0; f_sign <= 1'b0; f_idx <= 1'b0; end
      if (clr_er) f_err <= 1'b0;
      if (step && !load_any) begin
        f_dir <= cnt_up;
        if (hit_c) begin f_car <= 1'b1; f_sign <= 1'b0; end
        if (hit_b) begin f_bor <= 1'b1; f_sign <= 1'b1; end
        if (nxt == preset) f_cmp <= 1'b1;
      end
      if (noise_in) f_err <= 1'b1;
      if (idx_evt) f_idx <= 1'b1;
    end
  end

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) ptr < PW'(BYTES));
  // R12
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !load_any) |=> $stable(cnt));
  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !load_any) |=> $stable(cnt));
  // R6
  rlim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_any && cmode == M_RLIM && cnt_up && cnt == preset) |=> $stable(cnt));
  // R8
  modn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_any && cmode == M_MODN && cnt_up && cnt == preset) |=> cnt == '0);
  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n) noise_in |=> f_err);
endmodule

// File: tb/preset_counter_ch_tb.sv
module preset_counter_ch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {mode[1:0], up, steps[7:0], preset[23:0], start[23:0], expected[23:0]}
  localparam logic [82:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'd3, 24'd10,      24'd5,        24'd8},
    {2'd0, 1'b1, 8'd3, 24'd0,       24'hFFFFFE,   24'd1},
    {2'd0, 1'b0, 8'd3, 24'd0,       24'd1,        24'hFFFFFE},
    {2'd1, 1'b1, 8'd5, 24'd10,      24'd8,        24'd10},
    {2'd1, 1'b0, 8'd5, 24'd10,      24'd2,        24'd0},
    {2'd2, 1'b1, 8'd4, 24'd0,       24'hFFFFFE,   24'd0},
    {2'd2, 1'b0, 8'd4, 24'd5,       24'd1,        24'hFFFFFF},
    {2'd3, 1'b1, 8'd3, 24'd4,       24'd3,        24'd1},
    {2'd3, 1'b0, 8'd3, 24'd4,       24'd1,        24'd3},
    {2'd0, 1'b1, 8'd0, 24'd0,       24'd0,        24'd0}
  };

  logic clk = 0, rst_n = 0;
  logic bus_ctrl = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, psc_o;
  logic cnt_en = 0, cnt_up = 1, index_pin = 0, noise_in = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preset_counter_ch dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ctrl(bus_ctrl), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .index_pin(index_pin), .noise_in(noise_in), .psc_o(psc_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_w(input logic ctl, input logic [7:0] d);
    @(negedge clk); bus_ctrl = ctl; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_r(input logic ctl, output logic [7:0] d);
    @(negedge clk); bus_ctrl = ctl; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic set_preset(input logic [23:0] v);
    bus_w(1, 8'h01);
    bus_w(0, v[7:0]); bus_w(0, v[15:8]); bus_w(0, v[23:16]);
  endtask

  task automatic read_bytes(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    bus_r(0, b0); bus_r(0, b1); bus_r(0, b2);
    v = {b2, b1, b0};
  endtask

  task automatic read_cnt(output logic [23:0] v);
    bus_w(1, 8'h11);
    read_bytes(v);
  endtask

  task automatic pulses(input int n, input logic up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1; cnt_up = up;
      @(negedge clk); cnt_en = 0;
    end
  endtask

  task automatic load_count(input logic [23:0] v);
    set_preset(v);
    bus_w(1, 8'h08);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] s, b;
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_r(1, s); chk("R1 status", s, 8'h20);
    read_bytes(v); chk("R1 latch", v, 24'h0);
    chk("R1 psc", psc_o, 8'h00);
    // R12 gate off after reset
    pulses(3, 1); read_cnt(v); chk("R12 gated off", v, 24'h0);

    // table: R2 mode select, R5..R8 modes
    for (int k = 0; k < NV; k++) begin
      logic [82:0] e;
      string req;
      e = VEC[k];
      case (e[82:81]) 2'd0: req = "R5 normal"; 2'd1: req = "R6 range limit";
        2'd2: req = "R7 non-recycle"; default: req = "R8 modulo-N"; endcase
      bus_w(1, 8'h41);
      bus_w(1, 8'h20 | {5'd0, e[82:81], 1'b0});
      load_count(e[47:24]);
      set_preset(e[71:48]);
      pulses(int'(e[79:72]), e[80]);
      read_cnt(v);
      chk(req, {8'h0, v}, {8'h0, e[23:0]});
    end

    // R3 pointer, R4 transfers
    bus_w(1, 8'h20);
    load_count(24'h123456);
    bus_w(1, 8'h10);
    bus_r(0, b); chk("R3 byte0", b, 8'h56);
    bus_w(1, 8'h01);
    bus_r(0, b); chk("R3 pointer reset", b, 8'h56);
    bus_r(0, b); chk("R3 byte1", b, 8'h34);
    bus_r(0, b); chk("R3 byte2", b, 8'h12);
    bus_r(0, b); chk("R3 wrap", b, 8'h56);
    bus_w(1, 8'h18); @(negedge clk); chk("R4 prescaler", psc_o, 8'h56);
    pulses(1, 1);
    bus_w(1, 8'h01); read_bytes(v); chk("R4 latch holds", v, 24'h123456);
    read_cnt(v); chk("R4 relatch", v, 24'h123457);

    // R9 compare, R10 clear
    bus_w(1, 8'h04); bus_w(1, 8'h06);
    load_count(24'd8); set_preset(24'd10);
    pulses(2, 1);
    bus_r(1, s); chk("R9 compare set", s, 8'h24);
    bus_w(1, 8'h04);
    bus_r(1, s); chk("R10 flags cleared", s, 8'h20);
    // R11 direction
    pulses(1, 0);
    bus_r(1, s); chk("R11 direction down", s, 8'h00);
    // R10 error flag
    @(negedge clk); noise_in = 1; @(negedge clk); noise_in = 0;
    bus_r(1, s); chk("R10 error set", s, 8'h10);
    bus_w(1, 8'h06);
    bus_r(1, s); chk("R10 error cleared", s, 8'h00);
    // R5 carry/borrow/sign in status
    load_count(24'hFFFFFF);
    pulses(1, 1);
    bus_r(1, s); chk("R5 carry", s, 8'h22);
    pulses(1, 0);
    bus_r(1, s); chk("R5 borrow sign", s, 8'h0F);
    bus_w(1, 8'h04);

    // R13 index load
    set_preset(24'h000777);
    bus_w(1, 8'h41); bus_w(1, 8'h63);
    @(negedge clk); index_pin = 1; @(negedge clk); @(negedge clk);
    read_cnt(v); chk("R13 index load", v, 24'h000777);
    bus_r(1, s); chk("R13 index flag", s, 8'h40);
    @(negedge clk); index_pin = 0; @(negedge clk);
    bus_w(1, 8'h04);
    bus_w(1, 8'h43);
    set_preset(24'h000888);
    @(negedge clk); index_pin = 1; @(negedge clk); @(negedge clk);
    read_cnt(v); chk("R13 index load blocked", v, 24'h000777);
    bus_r(1, s); chk("R13 flag when blocked", s, 8'h40);

    done = 1;
    finish_up();
  end
endmodule